// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a processor whose procedure calls slide a register window instead of spilling registers to memory. Software always sees 32 architectural registers. Eight of them are globals shared by every window. The other 24 form the current window: an out group, a local group and an in group. Behind them sits a physical array of 8 + NUM_WIN × 16 entries. Adjacent windows overlap, so the out group of a caller is physically the in group of the window it moves to on a call.

The block maps each architectural register number, through the current window pointer, to a physical entry. It serves two combinational read ports and one synchronous write port. The pointer moves on three strobes: save moves it down, while restore and return-from-trap move it up. A mask register marks which window is invalid. A move that would land on a marked window is refused, and the block raises an overflow or underflow flag that the trap logic outside then handles.

Top module: `winreg_file`

## Requirements
- R1: Architectural registers 1–7 map to the same physical entries in every window, so a value written to one of them in any window reads back unchanged from every other window.
- R2: Architectural register 0 always reads as zero on both read ports, and a write to it changes no register.
- R3: A committed save sets the window pointer to (pointer − 1) mod NUM_WIN. A committed restore or return-from-trap sets it to (pointer + 1) mod NUM_WIN. The pointer output shows the new value after the clock edge.
- R4: Registers 8–15 (out group) of window w are the same physical entries as registers 24–31 (in group) of window (w − 1) mod NUM_WIN. Registers 16–23 (local group) belong to a single window only.
- R5: The windows form a ring. A save from window 0 selects window NUM_WIN−1, and a restore from window NUM_WIN−1 selects window 0.
- R6: A save whose target window has its bit set in the invalid mask leaves the pointer unchanged. It drives ovf_trap high for exactly the cycle after the request, and the write port does nothing in that cycle.
- R7: A restore or return-from-trap whose target window has its mask bit set leaves the pointer unchanged. It drives unf_trap high for exactly the cycle after the request, and the write port does nothing in that cycle.
- R8: Reads always use the window pointer from before the clock edge. In a cycle where the pointer moves, the write goes to the entry selected through the new pointer.
- R9: The invalid mask is loaded from wim_wdata when wim_we is high. The trap test in that same cycle uses the old mask. When the mask is all zero, no move ever traps.
- R10: After reset the window pointer is 0, the mask is 0x80 (bit 7 = window 7 invalid), both trap flags are low and every register reads as zero.
- R11: When save is requested together with restore or return-from-trap, only the save is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_addr | input | 5 | Architectural register for read port A |
| rd_a_data | output | DATA_W | Read port A data (combinational) |
| rd_b_addr | input | 5 | Architectural register for read port B |
| rd_b_data | output | DATA_W | Read port B data (combinational) |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Architectural destination register |
| wr_data | input | DATA_W | Write data |
| do_save | input | 1 | Move the window pointer down (call) |
| do_restore | input | 1 | Move the window pointer up (return) |
| do_rett | input | 1 | Move the window pointer up (return from trap) |
| wim_we | input | 1 | Load the invalid-window mask |
| wim_wdata | input | NUM_WIN | New invalid-window mask |
| cwp | output | 5 | Current window pointer |
| wim | output | NUM_WIN | Current invalid-window mask |
| ovf_trap | output | 1 | Refused save, high for one cycle |
| unf_trap | output | 1 | Refused restore or return-from-trap, high for one cycle |

## Verification
Directed sequences come first. One writes an out register, then saves and reads the same value from an in register, which separates a correct overlap from an off-by-one-window mapping. Others save from window 0 and restore from window 7 with a zero mask, which exposes a ring that fails to wrap. Targeted mask values place the invalid window right where a save or a restore lands, and both a refused move and a write issued in the same cycle are then checked. A seeded random mix of strobes, writes and single-bit or zero masks follows, compared against a reference model, to reach collisions between writes, moves and mask updates that the directed cases do not cover.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
    // Architectural register number width and group size are fixed by the register model
    localparam int unsigned ARCH_W = 5;
    localparam int unsigned GRP    = 8;
    localparam int unsigned OFF_W  = $clog2(GRP);
    localparam int unsigned CWP_W  = 5;

    typedef logic [ARCH_W-1:0] arch_idx_t;

    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_IN     = 2'd3
    } grp_e;
endpackage

// File: rtl/wrf_map.sv
module wrf_map
    import wrf_pkg::*;
#(
    parameter int unsigned NUM_WIN = 8,
    parameter int unsigned PHYS_W  = 8
) (
    input  arch_idx_t          arch,
    input  logic [CWP_W-1:0]   win,
    output logic [PHYS_W-1:0]  phys
);
    localparam int unsigned SPAN = 2 * GRP;

    grp_e               grp;
    logic [CWP_W-1:0]   nbr;
    logic [PHYS_W-1:0]  own_base;
    logic [PHYS_W-1:0]  nbr_base;
    logic [PHYS_W-1:0]  off;

    always_comb begin
        grp      = grp_e'(arch[ARCH_W-1:OFF_W]);
        nbr      = (win == CWP_W'(NUM_WIN - 1)) ? '0 : win + CWP_W'(1);
        off      = PHYS_W'(arch[OFF_W-1:0]);
        own_base = PHYS_W'(GRP) + PHYS_W'(win) * PHYS_W'(SPAN);
        nbr_base = PHYS_W'(GRP) + PHYS_W'(nbr) * PHYS_W'(SPAN);
        unique case (grp)
            GRP_GLOBAL: phys = off;
            GRP_OUT:    phys = own_base + off;
            GRP_LOCAL:  phys = own_base + PHYS_W'(GRP) + off;
            default:    phys = nbr_base + off;  // in group = out group of the upper neighbour
        endcase
    end
endmodule

// File: rtl/wrf_wctl.sv
module wrf_wctl
    import wrf_pkg::*;
#(
    parameter int unsigned NUM_WIN = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               do_save,
    input  logic               do_restore,
    input  logic               do_rett,
    input  logic               wim_we,
    input  logic [NUM_WIN-1:0] wim_wdata,
    output logic [CWP_W-1:0]   cwp_q_o,
    output logic [CWP_W-1:0]   cwp_nx_o,
    output logic               block_o,
    output logic [NUM_WIN-1:0] wim_q_o,
    output logic               ovf_q_o,
    output logic               unf_q_o
);
    localparam logic [NUM_WIN-1:0] WIM_RST = NUM_WIN'(1) << (NUM_WIN - 1);

    typedef struct packed {
        logic [CWP_W-1:0]   cwp;
        logic [NUM_WIN-1:0] wim;
        logic               ovf;
        logic               unf;
    } ctl_t;

    ctl_t             st_d, st_q;
    logic [CWP_W-1:0] dec_w, inc_w, tgt_w;
    logic             hit_d;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        dec_w    = (st_q.cwp == '0) ? CWP_W'(NUM_WIN - 1) : st_q.cwp - CWP_W'(1);
        inc_w    = (st_q.cwp == CWP_W'(NUM_WIN - 1)) ? '0 : st_q.cwp + CWP_W'(1);
        tgt_w    = st_q.cwp;
        hit_d    = 1'b0;
        if (do_save) begin
            tgt_w    = dec_w;
            hit_d    = |(st_q.wim & (NUM_WIN'(1) << dec_w));
            st_d.ovf = hit_d;
        end else if (do_restore || do_rett) begin
            tgt_w    = inc_w;
            hit_d    = |(st_q.wim & (NUM_WIN'(1) << inc_w));
            st_d.unf = hit_d;
        end
        if (!hit_d) st_d.cwp = tgt_w;
        if (wim_we) st_d.wim = wim_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cwp: '0, wim: WIM_RST, ovf: 1'b0, unf: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cwp_q_o  = st_q.cwp;
    assign cwp_nx_o = st_d.cwp;
    assign block_o  = hit_d;
    assign wim_q_o  = st_q.wim;
    assign ovf_q_o  = st_q.ovf;
    assign unf_q_o  = st_q.unf;

    AST_CWP_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cwp < CWP_W'(NUM_WIN)); // R3
    AST_ONE_TRAP_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.ovf && st_q.unf)); // R7
    AST_OVF_HOLDS_CWP: assert property (@(posedge clk) disable iff (!rst_n)
        do_save |=> (ovf_q_o ? $stable(cwp_q_o) : cwp_q_o != $past(cwp_q_o))); // R6
    AST_SAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (do_save && $past(cwp_q_o) == cwp_q_o) |=> (ovf_q_o ||
        cwp_q_o == (($past(cwp_q_o) == '0) ? CWP_W'(NUM_WIN - 1) : $past(cwp_q_o) - CWP_W'(1)))); // R3
    AST_ZERO_MASK_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wim_q_o == '0) |=> (!ovf_q_o && !unf_q_o)); // R9
endmodule

// File: rtl/wrf_array.sv
module wrf_array #(
    parameter int unsigned DEPTH  = 136,
    parameter int unsigned AW     = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NRD    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NRD-1:0][AW-1:0]     rd_idx,
    output logic [NRD-1:0][DATA_W-1:0] rd_data,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_idx,
    input  logic [DATA_W-1:0]          wr_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = mem_q[rd_idx[p]];
    end
endmodule

// File: rtl/winreg_file.sv
module winreg_file
    import wrf_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_WIN = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [4:0]         rd_a_addr,
    output logic [DATA_W-1:0]  rd_a_data,
    input  logic [4:0]         rd_b_addr,
    output logic [DATA_W-1:0]  rd_b_data,
    input  logic               wr_en,
    input  logic [4:0]         wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               do_save,
    input  logic               do_restore,
    input  logic               do_rett,
    input  logic               wim_we,
    input  logic [NUM_WIN-1:0] wim_wdata,
    output logic [4:0]         cwp,
    output logic [NUM_WIN-1:0] wim,
    output logic               ovf_trap,
    output logic               unf_trap
);
    localparam int unsigned PHYS_N = GRP + NUM_WIN * 2 * GRP;
    localparam int unsigned PHYS_W = $clog2(PHYS_N);
    localparam int unsigned NRD    = 2;

    logic [CWP_W-1:0]              cwp_q, cwp_nx;
    logic                          blocked;
    logic [NRD-1:0][ARCH_W-1:0]    rd_arch;
    logic [NRD-1:0][PHYS_W-1:0]    rd_phys;
    logic [NRD-1:0][DATA_W-1:0]    rd_raw;
    logic [PHYS_W-1:0]             wr_phys;
    logic                          wr_go;

    wrf_wctl #(.NUM_WIN(NUM_WIN)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .do_save(do_save), .do_restore(do_restore), .do_rett(do_rett),
        .wim_we(wim_we), .wim_wdata(wim_wdata),
        .cwp_q_o(cwp_q), .cwp_nx_o(cwp_nx), .block_o(blocked),
        .wim_q_o(wim), .ovf_q_o(ovf_trap), .unf_q_o(unf_trap)
    );

    assign rd_arch[0] = rd_a_addr;
    assign rd_arch[1] = rd_b_addr;

    // Reads go through the pointer held before the edge
    for (genvar p = 0; p < NRD; p++) begin : g_rmap
        wrf_map #(.NUM_WIN(NUM_WIN), .PHYS_W(PHYS_W)) u_map (
            .arch(rd_arch[p]), .win(cwp_q), .phys(rd_phys[p])
        );
    end

    // The write goes through the pointer that the edge will commit
    wrf_map #(.NUM_WIN(NUM_WIN), .PHYS_W(PHYS_W)) u_wmap (
        .arch(wr_addr), .win(cwp_nx), .phys(wr_phys)
    );

    assign wr_go = wr_en && (wr_addr != '0) && !blocked;

    wrf_array #(.DEPTH(PHYS_N), .AW(PHYS_W), .DATA_W(DATA_W), .NRD(NRD)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rd_phys), .rd_data(rd_raw),
        .wr_en(wr_go), .wr_idx(wr_phys), .wr_data(wr_data)
    );

    assign rd_a_data = (rd_a_addr == '0) ? '0 : rd_raw[0];
    assign rd_b_data = (rd_b_addr == '0) ? '0 : rd_raw[1];
    assign cwp       = cwp_q;

    AST_ZERO_REG_A: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr == '0) |-> (rd_a_data == '0)); // R2
    AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == rd_b_addr && blocked) |=> $stable(rd_b_data) || !$stable(cwp) || !$stable(rd_b_addr)); // R6
endmodule

// File: tb/winreg_file_bench.sv
module winreg_file_bench;
    localparam int NW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, do_save = 1'b0, do_restore = 1'b0, do_rett = 1'b0, wim_we = 1'b0;
    logic [7:0]  wim_wdata = '0, wim;
    logic [4:0]  cwp;
    logic        ovf_trap, unf_trap;

    winreg_file u_winreg_file (
        .clk(clk), .rst_n(rst_n),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .do_save(do_save), .do_restore(do_restore), .do_rett(do_rett),
        .wim_we(wim_we), .wim_wdata(wim_wdata),
        .cwp(cwp), .wim(wim), .ovf_trap(ovf_trap), .unf_trap(unf_trap)
    );

    always #5 clk = ~clk;

    int          n_chk = 0, n_bad = 0;
    bit          done = 0;
    logic [31:0] mdl [8 + NW*16];
    int          m_cwp;
    logic [7:0]  m_wim;
    logic        m_ovf, m_unf;

    function automatic int pmap(int a, int w);
        if (a < 8)  return a;
        if (a < 16) return 8 + w*16 + (a - 8);
        if (a < 24) return 16 + w*16 + (a - 16);
        return 8 + ((w + 1) % NW)*16 + (a - 24);
    endfunction

    function automatic logic [31:0] exp_rd(int a);
        return (a == 0) ? 32'd0 : mdl[pmap(a, m_cwp)];
    endfunction

    function automatic string rtag(int a);
        if (a == 0) return "R2";
        if (a < 8)  return "R1";
        return "R4";
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h, expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Called at a falling edge; returns at the next falling edge after checking
    task automatic step(logic sv, logic rs, logic rt, logic we, logic [4:0] wa, logic [31:0] wd,
                        logic [4:0] ra, logic [4:0] rb, logic mwe, logic [7:0] mwd, string ptag);
        int  nxt;
        logic hit;
        do_save = sv; do_restore = rs; do_rett = rt;
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_a_addr = ra; rd_b_addr = rb; wim_we = mwe; wim_wdata = mwd;
        #1;
        check(rtag(ra), rd_a_data, exp_rd(ra));  // reads through the old window (R8)
        check(rtag(rb), rd_b_data, exp_rd(rb));
        nxt = m_cwp; hit = 0; m_ovf = 0; m_unf = 0;
        if (sv) begin
            nxt = (m_cwp + NW - 1) % NW; hit = m_wim[nxt]; m_ovf = hit;
        end else if (rs || rt) begin
            nxt = (m_cwp + 1) % NW; hit = m_wim[nxt]; m_unf = hit;
        end
        if (!hit) m_cwp = nxt;
        if (we && wa != 0 && !hit) mdl[pmap(wa, m_cwp)] = wd;
        if (mwe) m_wim = mwd;
        @(posedge clk);
        @(negedge clk);
        check(ptag, 32'(cwp), 32'(m_cwp));
        check("R6", 32'(ovf_trap), 32'(m_ovf));
        check("R7", 32'(unf_trap), 32'(m_unf));
        check("R9", 32'(wim), 32'(m_wim));
    endtask

    task automatic idle_rd(logic [4:0] ra, string tag, logic [31:0] exp);
        rd_a_addr = ra; #1;
        check(tag, rd_a_data, exp);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin : main
        void'($urandom(32'd4711));
        for (int i = 0; i < 8 + NW*16; i++) mdl[i] = '0;
        m_cwp = 0; m_wim = 8'h80;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        check("R10", 32'(cwp), 0);
        check("R10", 32'(wim), 32'h80);
        check("R10", 32'({ovf_trap, unf_trap}), 0);
        for (int a = 0; a < 32; a++) begin
            rd_a_addr = 5'(a); #1;
            check("R10", rd_a_data, 0);
        end

        // R2: write to r0 dropped; R1: global write
        step(0,0,0, 1, 5'd0, 32'hDEAD_0000, 5'd0, 5'd0, 0, 8'h0, "R3");
        step(0,0,0, 1, 5'd5, 32'h0000_0555, 5'd0, 5'd5, 0, 8'h0, "R3");
        // R6: save from 0 lands on 7 (invalid); write to r16 suppressed
        step(1,0,0, 1, 5'd16, 32'hBAD0_0016, 5'd16, 5'd5, 0, 8'h0, "R6");
        idle_rd(5'd16, "R6", 32'd0);
        // R3: restore 0 -> 1, then write an out register
        step(0,1,0, 0, 5'd0, 0, 5'd5, 5'd0, 0, 8'h0, "R3");
        step(0,0,0, 1, 5'd9, 32'h0BB0_0009, 5'd9, 5'd5, 0, 8'h0, "R3");
        // R4: after save to window 0, r25 is the old r9
        step(1,0,0, 0, 5'd0, 0, 5'd9, 5'd0, 0, 8'h0, "R3");
        idle_rd(5'd25, "R4", 32'h0BB0_0009);
        // R7: mask window 1 invalid, then a return-from-trap from 0 traps
        step(0,0,0, 0, 5'd0, 0, 5'd0, 5'd0, 1, 8'h02, "R9");
        step(0,0,1, 1, 5'd17, 32'hBAD0_0017, 5'd0, 5'd0, 0, 8'h0, "R7");
        // R9: mask load and move in same cycle uses the old mask
        step(0,1,0, 0, 5'd0, 0, 5'd0, 5'd0, 1, 8'h00, "R9");
        // R5: zero mask, full ring downwards and upwards
        for (int k = 0; k < 9; k++)
            step(1,0,0, 1, 5'd20, 32'h5000_0000 + 32'(k), 5'd20, 5'd12, 0, 8'h0, "R5");
        for (int k = 0; k < 9; k++)
            step(0,k[0],~k[0], 0, 5'd0, 0, 5'd20, 5'd28, 0, 8'h0, "R5");
        // R11: save together with restore performs the save
        step(1,1,1, 0, 5'd0, 0, 5'd0, 5'd0, 0, 8'h0, "R11");
        // R8: write with a save in the same cycle lands in the new window
        step(1,0,0, 1, 5'd18, 32'h8888_0018, 5'd18, 5'd0, 0, 8'h0, "R8");
        idle_rd(5'd18, "R8", 32'h8888_0018);

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] mw;
            mw = (($urandom % 3) == 0) ? 8'h00 : (8'h01 << ($urandom % 8));
            step(($urandom % 4) == 0, ($urandom % 6) == 0, ($urandom % 8) == 0,
                 ($urandom % 2) == 0, 5'($urandom), $urandom,
                 5'($urandom), 5'($urandom), ($urandom % 12) == 0, mw, "R3");
        end
        finish_run();
    end
endmodule